// File: doc/BRIEF.md
# Word-Serial Modular Adder-Subtractor

This block adds or subtracts two multi-word residues modulo twice an odd modulus. The operands, the doubled modulus and two result locations (a primary result `z` and a scratch location `t`) sit in an external word-addressed register file. The block reads and writes one word per cycle, least significant word first, through one row of full adders. The carry is held in a single flip-flop between words. Each operand is `E = ceil((N_BITS+1)/W_BITS)` words wide, and both inputs are assumed to be already below the doubled modulus.

An addition takes three passes. The first writes the raw sum to `z`. The second writes the sum minus the doubled modulus to `t`. The third copies either `t` or `z` back into `z`, depending on the sign of the second pass. A subtraction takes two passes. The first writes the raw difference to `z` and `t` in the same cycle. The second rewrites `z` as `t` plus the doubled modulus when the difference was negative, or as `t` plus zero otherwise.

Each pass lasts `E+1` cycles whatever the data, so that many units fed one command stream stay in lockstep. A start pulse is accepted only when the block is idle. A one-cycle done pulse closes every operation.

Top module: `wsa_modadd`

## Requirements
- R1: Within each pass the word index on `word_o` starts at 0 and increases by one per written word; writes happen only for indices 0 to E-1.
- R2: After an addition, `z` holds (x+y) − 2N when x+y ≥ 2N, and x+y otherwise. The sign comparison includes any carry out of the top word.
- R3: After an addition, `t` always holds (x+y−2N) mod 2^(E·W_BITS), whether or not it was selected.
- R4: After a subtraction, `z` holds x−y when x ≥ y, and x−y+2N otherwise.
- R5: A subtraction writes the raw difference to `z` and to `t` in the same cycle, so that `t` ends up holding (x−y) mod 2^(E·W_BITS).
- R6: From the clock edge that accepts start, `done_o` is high on the 3(E+1)-th rising edge count for an addition and on the 2(E+1)-th for a subtraction. This holds for every operand value.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is low in the following cycle.
- R8: A start pulse while `busy_o` is high is ignored. The running operation keeps its mode, its register selects and its latency.
- R9: Carries and borrows propagate across word boundaries, including a sum that overflows the top word.
- R10: After reset, `busy_o`, `done_o` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken when idle |
| sub_i | input | 1 | 1 selects subtraction, 0 selects addition |
| x_sel_i | input | RAW | Register index of x |
| y_sel_i | input | RAW | Register index of y |
| z_sel_i | input | RAW | Register index of the result z |
| t_sel_i | input | RAW | Register index of the scratch t |
| m_sel_i | input | RAW | Register index of the doubled modulus 2N |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| word_o | output | CW | Word index for all reads and writes |
| rd_a_sel_o | output | RAW | Register index, read port A |
| rd_b_sel_o | output | RAW | Register index, read port B |
| rd_a_i | input | W_BITS | Read data, port A (combinational read) |
| rd_b_i | input | W_BITS | Read data, port B (combinational read) |
| wr_z_en_o | output | 1 | Write enable for z |
| wr_z_sel_o | output | RAW | Register index for the z write |
| wr_t_en_o | output | 1 | Write enable for t |
| wr_t_sel_o | output | RAW | Register index for the t write |
| wr_data_o | output | W_BITS | Write data shared by both write ports |

## Verification
The bench drives additions that stay below the doubled modulus, that land exactly on it, and that overflow the top word. A design that ignored the top-word carry would keep the unreduced sum, and one that compared with the wrong sense would return a value off by 2N. Subtractions cover positive, negative and zero differences: a sign decision taken from the wrong carry adds 2N to a correct result or leaves a negative one wrapped. Carry runs across every word boundary expose a carry flip-flop that is not chained or that leaks between passes. Latency is measured for both correcting and non-correcting data, and a mid-operation start request must not shorten, restart or redirect the running operation.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
  typedef enum logic [1:0] {
    B_PLAIN = 2'd0,
    B_INV   = 2'd1,
    B_ZERO  = 2'd2
  } bmode_e;
endpackage

// File: rtl/wsa_seq.sv
module wsa_seq #(
  parameter int E  = 4,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          sub_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          sub_mode_o,
  output logic [1:0]    pass_o,
  output logic [CW-1:0] cnt_o,
  output logic          word_vld_o,
  output logic          first_word_o,
  output logic          last_word_o,
  output logic          pass_end_o,
  output logic          done_o
);
  logic          busy_q, sub_q;
  logic [1:0]    pass_q, last_pass;
  logic [CW-1:0] cnt_q;

  assign last_pass    = sub_q ? 2'd1 : 2'd2;
  assign accept_o     = start_i && !busy_q;
  assign busy_o       = busy_q;
  assign sub_mode_o   = sub_q;
  assign pass_o       = pass_q;
  assign cnt_o        = cnt_q;
  assign word_vld_o   = busy_q && (cnt_q < CW'(E));
  assign first_word_o = busy_q && (cnt_q == '0);
  assign last_word_o  = busy_q && (cnt_q == CW'(E-1));
  assign pass_end_o   = busy_q && (cnt_q == CW'(E));
  assign done_o       = pass_end_o && (pass_q == last_pass);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sub_q  <= 1'b0;
      pass_q <= 2'd0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        sub_q  <= sub_i;
        pass_q <= 2'd0;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CW'(E)) begin
      cnt_q <= '0;
      if (pass_q == last_pass) busy_q <= 1'b0;
      else                     pass_q <= pass_q + 2'd1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wsa_word_adder.sv
module wsa_word_adder
  import wsa_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  bmode_e       bmode_i,
  input  logic         cin_init_i,
  input  logic         first_i,
  input  logic         step_i,
  input  logic         clr_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic         carry_q, c_in;
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  always_comb begin
    unique case (bmode_i)
      B_INV:   b_eff = ~b_i;
      B_ZERO:  b_eff = '0;
      default: b_eff = b_i;
    endcase
  end

  // first word of a pass takes the pass carry-in, later words the chained carry
  assign c_in   = first_i ? cin_init_i : carry_q;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_in};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     carry_q <= 1'b0;
    else if (clr_i)  carry_q <= 1'b0;
    else if (step_i) carry_q <= cout_o;
  end
endmodule

// File: rtl/wsa_sign.sv
module wsa_sign (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sub_mode_i,
  input  logic [1:0] pass_i,
  input  logic       last_word_i,
  input  logic       cout_i,
  output logic       corr_o
);
  logic ovf_q, corr_q;

  assign corr_o = corr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      corr_q <= 1'b0;
    end else if (last_word_i) begin
      if (sub_mode_i) begin
        // no carry out of x + ~y + 1 means x < y
        if (pass_i == 2'd0) corr_q <= !cout_i;
      end else begin
        if (pass_i == 2'd0) ovf_q  <= cout_i;
        // sum - 2N non-negative: sum overflowed, or no borrow in the trial pass
        if (pass_i == 2'd1) corr_q <= ovf_q | cout_i;
      end
    end
  end
endmodule

// File: rtl/wsa_modadd.sv
module wsa_modadd
  import wsa_pkg::*;
#(
  parameter int N_BITS   = 31,
  parameter int W_BITS   = 8,
  parameter int NUM_REGS = 8,
  localparam int E       = (N_BITS + 1 + W_BITS - 1) / W_BITS,
  localparam int CW      = $clog2(E + 1),
  localparam int RAW     = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic [RAW-1:0]    x_sel_i,
  input  logic [RAW-1:0]    y_sel_i,
  input  logic [RAW-1:0]    z_sel_i,
  input  logic [RAW-1:0]    t_sel_i,
  input  logic [RAW-1:0]    m_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CW-1:0]     word_o,
  output logic [RAW-1:0]    rd_a_sel_o,
  output logic [RAW-1:0]    rd_b_sel_o,
  input  logic [W_BITS-1:0] rd_a_i,
  input  logic [W_BITS-1:0] rd_b_i,
  output logic              wr_z_en_o,
  output logic [RAW-1:0]    wr_z_sel_o,
  output logic              wr_t_en_o,
  output logic [RAW-1:0]    wr_t_sel_o,
  output logic [W_BITS-1:0] wr_data_o
);
  logic           accept, busy, sub_mode, word_vld, first_word, last_word, pass_end;
  logic [1:0]     pass;
  logic [CW-1:0]  cnt;
  logic           corr, cout, cin_init, wz, wt;
  bmode_e         bmode;
  logic [RAW-1:0] x_q, y_q, z_q, t_q, m_q;

  wsa_seq #(.E(E), .CW(CW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .sub_i       (sub_i),
    .accept_o    (accept),
    .busy_o      (busy),
    .sub_mode_o  (sub_mode),
    .pass_o      (pass),
    .cnt_o       (cnt),
    .word_vld_o  (word_vld),
    .first_word_o(first_word),
    .last_word_o (last_word),
    .pass_end_o  (pass_end),
    .done_o      (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; y_q <= '0; z_q <= '0; t_q <= '0; m_q <= '0;
    end else if (accept) begin
      x_q <= x_sel_i; y_q <= y_sel_i; z_q <= z_sel_i;
      t_q <= t_sel_i; m_q <= m_sel_i;
    end
  end

  // pass routing: operand sources, b-operand treatment, carry-in, targets
  always_comb begin
    rd_a_sel_o = x_q;
    rd_b_sel_o = y_q;
    bmode      = B_PLAIN;
    cin_init   = 1'b0;
    wz         = 1'b0;
    wt         = 1'b0;
    unique case ({sub_mode, pass})
      3'b0_00: begin wz = 1'b1; end
      3'b0_01: begin
        rd_a_sel_o = z_q; rd_b_sel_o = m_q;
        bmode = B_INV; cin_init = 1'b1; wt = 1'b1;
      end
      3'b0_10: begin
        rd_a_sel_o = corr ? t_q : z_q; rd_b_sel_o = m_q;
        bmode = B_ZERO; wz = 1'b1;
      end
      3'b1_00: begin
        bmode = B_INV; cin_init = 1'b1; wz = 1'b1; wt = 1'b1;
      end
      3'b1_01: begin
        rd_a_sel_o = t_q; rd_b_sel_o = m_q;
        bmode = corr ? B_PLAIN : B_ZERO; wz = 1'b1;
      end
      default: ;
    endcase
  end

  wsa_word_adder #(.W(W_BITS)) u_add (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (rd_a_i),
    .b_i       (rd_b_i),
    .bmode_i   (bmode),
    .cin_init_i(cin_init),
    .first_i   (first_word),
    .step_i    (word_vld),
    .clr_i     (pass_end),
    .sum_o     (wr_data_o),
    .cout_o    (cout)
  );

  wsa_sign u_sign (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sub_mode_i (sub_mode),
    .pass_i     (pass),
    .last_word_i(last_word),
    .cout_i     (cout),
    .corr_o     (corr)
  );

  assign busy_o     = busy;
  assign word_o     = cnt;
  assign wr_z_en_o  = word_vld && wz;
  assign wr_t_en_o  = word_vld && wt;
  assign wr_z_sel_o = z_q;
  assign wr_t_sel_o = t_q;
endmodule

// File: rtl/wsa_modadd_chk.sv
module wsa_modadd_chk #(
  parameter int N_BITS = 31,
  parameter int W_BITS = 8,
  localparam int E     = (N_BITS + 1 + W_BITS - 1) / W_BITS,
  localparam int CW    = $clog2(E + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          sub_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] word_o,
  input logic          wr_z_en_o,
  input logic          wr_t_en_o
);
  logic [15:0] lat_q;
  logic        mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      mode_q <= 1'b0;
    end else if (start_i && !busy_o) begin
      lat_q  <= '0;
      mode_q <= sub_i;
    end else if (busy_o) begin
      lat_q  <= lat_q + 16'd1;
    end
  end

  assert_idle_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!wr_z_en_o && !wr_t_en_o && !done_o));

  assert_word_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_z_en_o || wr_t_en_o) |-> (word_o < CW'(E)));

  assert_word_ascends_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_z_en_o || wr_t_en_o) && word_o != '0) |-> ($past(word_o) == word_o - 1'b1));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_busy_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_fixed_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == (mode_q ? 16'(2*(E+1)-1) : 16'(3*(E+1)-1))));

  assert_dual_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_t_en_o |-> (wr_z_en_o == mode_q));
endmodule

bind wsa_modadd wsa_modadd_chk #(.N_BITS(N_BITS), .W_BITS(W_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .sub_i    (sub_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .word_o   (word_o),
  .wr_z_en_o(wr_z_en_o),
  .wr_t_en_o(wr_t_en_o)
);

// File: tb/sim_wsa_modadd.sv
module sim_wsa_modadd;
  localparam int E   = 4;
  localparam longint MASK = 64'hFFFF_FFFF;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       start_i = 1'b0, sub_i = 1'b0;
  logic [2:0] x_sel_i = 3'd0, y_sel_i = 3'd1, z_sel_i = 3'd2, t_sel_i = 3'd3, m_sel_i = 3'd4;
  logic       busy_o, done_o;
  logic [2:0] word_o, rd_a_sel_o, rd_b_sel_o, wr_z_sel_o, wr_t_sel_o;
  logic [7:0] rd_a_i, rd_b_i, wr_data_o;
  logic       wr_z_en_o, wr_t_en_o;

  logic [7:0] mem [0:7][0:3];
  logic       ld_en = 1'b0;
  logic [2:0] ld_reg = '0;
  logic [1:0] ld_word = '0;
  logic [7:0] ld_data = '0;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  wsa_modadd u0 (.*);

  assign rd_a_i = (word_o < 3'(E)) ? mem[rd_a_sel_o][word_o[1:0]] : 8'h00;
  assign rd_b_i = (word_o < 3'(E)) ? mem[rd_b_sel_o][word_o[1:0]] : 8'h00;

  always @(posedge clk_i) begin
    if (ld_en) mem[ld_reg][ld_word] <= ld_data;
    if (wr_z_en_o) mem[wr_z_sel_o][word_o[1:0]] <= wr_data_o;
    if (wr_t_en_o) mem[wr_t_sel_o][word_o[1:0]] <= wr_data_o;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int r, input longint v);
    for (int w = 0; w < E; w++) begin
      @(negedge clk_i);
      ld_en = 1'b1; ld_reg = 3'(r); ld_word = 2'(w); ld_data = 8'(v >> (8*w));
    end
    @(negedge clk_i);
    ld_en = 1'b0;
  endtask

  function automatic longint get(input int r);
    longint v = 0;
    for (int w = 0; w < E; w++) v |= longint'(mem[r][w]) << (8*w);
    return v;
  endfunction

  // runs one op; poke=1 issues a conflicting start mid-operation (R8)
  task automatic run_op(input bit sub, input longint x, input longint y, input longint m,
                        input bit poke, input string tag);
    longint s, ez, et, lat_exp;
    int cyc = 0;
    put(0, x); put(1, y); put(4, m);
    put(2, 64'h5A5A5A5A); put(3, 64'hA5A5A5A5); put(5, 64'h3C3C3C3C);
    if (!sub) begin
      s  = x + y;
      et = (s - m) & MASK;
      ez = (s >= m) ? (s - m) : s;
      lat_exp = 3*(E+1);
    end else begin
      et = (x - y) & MASK;
      ez = (x >= y) ? (x - y) : (x - y + m);
      lat_exp = 2*(E+1);
    end
    @(negedge clk_i);
    sub_i = sub; z_sel_i = 3'd2; start_i = 1'b1;
    while (cyc < 200) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      start_i = 1'b0;
      if (poke && cyc == 3) begin start_i = 1'b1; sub_i = ~sub; z_sel_i = 3'd5; end
      if (poke && cyc == 4) begin z_sel_i = 3'd2; sub_i = sub; end
      if (done_o) break;
    end
    check(cyc == lat_exp, {tag, " R6 latency"}, cyc, lat_exp);
    @(negedge clk_i);
    check(!done_o && !busy_o, {tag, " R7 done single pulse"}, {done_o, busy_o}, 0);
    if (!sub) begin
      check(get(2) == ez, {tag, " R2 add z"}, get(2), ez);
      check(get(3) == et, {tag, " R3 add t"}, get(3), et);
    end else begin
      check(get(2) == ez, {tag, " R4 sub z"}, get(2), ez);
      check(get(3) == et, {tag, " R5 sub t"}, get(3), et);
    end
    if (poke) check(get(5) == 64'h3C3C3C3C, {tag, " R8 ignored start"}, get(5), 64'h3C3C3C3C);
  endtask

  task automatic t_reset;
    check(!busy_o && !done_o && !wr_z_en_o && !wr_t_en_o, "R10 reset idle",
          {busy_o, done_o, wr_z_en_o, wr_t_en_o}, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    // 2N = 0x00C0_0002 (N = 0x0060_0001)
    run_op(1'b0, 64'h0012_3456, 64'h0001_1111, 64'h00C0_0002, 1'b0, "add_nocorr");
    run_op(1'b0, 64'h0090_0000, 64'h0050_0000, 64'h00C0_0002, 1'b0, "add_corr");
    run_op(1'b0, 64'h0060_0001, 64'h0060_0001, 64'h00C0_0002, 1'b0, "add_eq2N");
    // R1 R9: carry runs through all low words
    run_op(1'b0, 64'h00FF_FFFF, 64'h0000_0001, 64'h0200_0002, 1'b0, "R1_R9_carry");
    // R9: sum overflows the top word, 2N = 0xFFFF_FFFE
    run_op(1'b0, 64'hFFFF_FFF0, 64'hFFFF_FFF0, 64'hFFFF_FFFE, 1'b0, "R9_overflow");
    run_op(1'b1, 64'h00A0_0000, 64'h0001_0001, 64'h00C0_0002, 1'b0, "sub_pos");
    run_op(1'b1, 64'h0000_0100, 64'h00B0_0000, 64'h00C0_0002, 1'b0, "sub_neg");
    run_op(1'b1, 64'h0033_3333, 64'h0033_3333, 64'h00C0_0002, 1'b0, "sub_zero");
    run_op(1'b1, 64'h0100_0000, 64'h0000_0001, 64'h0200_0002, 1'b0, "R9_borrow");
    run_op(1'b0, 64'h0090_0000, 64'h0050_0000, 64'h00C0_0002, 1'b1, "R8_add_poke");
    run_op(1'b1, 64'h0000_0100, 64'h00B0_0000, 64'h00C0_0002, 1'b1, "R8_sub_poke");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule